// File: doc/BRIEF.md
# Eight- or Nine-Input Ones-Counting Compressor

This block counts how many of its equally weighted input bits are set and returns that count as a 4-bit binary number. It is meant to sit in a column of a partial-product reduction array inside a parallel multiplier. There, a column of eight or nine dots of the same weight collapses into four dots of rising weight, and the next reduction level takes those four dots.

The count comes from a fixed tree of half and full adders, four stages deep. The first stage reduces the inputs in groups of three (or two) into sum/carry pairs. The second stage adds the three sums and, separately, the three carries. Two half adders then merge the remaining weight-2 and weight-4 terms. Each output bit therefore comes out in binary weight directly, with no extra adder stage, and no path is longer than six XOR levels. A parameter selects eight or nine inputs. The nine-input form turns the first-stage half adder into a full adder and keeps the rest of the tree unchanged. The block is purely combinational.

Top module: `ones_cnt_tree`

## Requirements
- R1: `count_o` equals the number of bits set in `bits_i`, as an unsigned binary number with bit 0 the least significant.
- R2: With every input set, `count_o` is 4'b1000 when NUM_IN is 8 and 4'b1001 when NUM_IN is 9.
- R3: With no input set, `count_o` is 4'b0000.
- R4: `count_o[0]` equals the XOR of all input bits.
- R5: `count_o` never exceeds NUM_IN.
- R6: The output depends only on how many inputs are set, not on which ones: any single set bit gives 1, and any two set bits give 2.
- R7: NUM_IN selects the eight- or nine-input tree. Any other value stops elaboration with an error.
- R8: The block holds no state. `count_o` follows a change on `bits_i` without any clock edge, and the same input always gives the same output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bits_i | input | NUM_IN | Equally weighted input bits to be counted |
| count_o | output | 4 | Binary count of set bits in `bits_i` |

## Verification
The checker evaluates four properties whenever the inputs change: the output matches the population count of the input, bit 0 equals the input parity, the count stays within NUM_IN, and the all-zero and all-one patterns give their fixed codes. The bench sweeps every input pattern of both the eight- and the nine-input builds. It also walks single bits and bit pairs to show that input position does not matter. It then repeats patterns without any clock activity to show that the output carries no memory.

// File: rtl/ones_cnt_pkg.sv
package ones_cnt_pkg;
  localparam int unsigned CNT_W = 4;
  typedef logic [CNT_W-1:0] cnt_t;
  typedef struct packed {
    logic s;
    logic c;
  } sc_t;
endpackage

// File: rtl/ones_cnt_ha.sv
module ones_cnt_ha
  import ones_cnt_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  output sc_t  sc_o
);
  assign sc_o.s = a_i ^ b_i;
  assign sc_o.c = a_i & b_i;
endmodule

// File: rtl/ones_cnt_fa.sv
module ones_cnt_fa
  import ones_cnt_pkg::*;
(
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output sc_t  sc_o
);
  logic p;
  assign p      = a_i ^ b_i;
  assign sc_o.s = p ^ c_i;
  assign sc_o.c = (a_i & b_i) | (p & c_i);
endmodule

// File: rtl/ones_cnt_tree.sv
module ones_cnt_tree
  import ones_cnt_pkg::*;
#(
  parameter int unsigned NUM_IN = 8
) (
  input  logic [NUM_IN-1:0] bits_i,
  output logic [CNT_W-1:0]  count_o
);
  localparam int unsigned LEAD_W = NUM_IN - 6;  // 2 or 3 bits in the lead group
  localparam int unsigned GRP_B  = LEAD_W;      // start of second group
  localparam int unsigned GRP_C  = LEAD_W + 3;  // start of third group

  sc_t grp [3];
  sc_t sum_tot, car_tot, w2_mrg, w4_mrg;

  // R7: lead group is a half adder (8 in) or a full adder (9 in)
  generate
    if (NUM_IN == 8) begin : g_lead_ha
      ones_cnt_ha u_lead (.a_i(bits_i[0]), .b_i(bits_i[1]), .sc_o(grp[0]));
    end else if (NUM_IN == 9) begin : g_lead_fa
      ones_cnt_fa u_lead (.a_i(bits_i[0]), .b_i(bits_i[1]), .c_i(bits_i[2]),
                          .sc_o(grp[0]));
    end else begin : g_bad_cfg
      $error("ones_cnt_tree: NUM_IN must be 8 or 9");
    end
  endgenerate

  ones_cnt_fa u_grp_b (.a_i(bits_i[GRP_B]), .b_i(bits_i[GRP_B+1]),
                       .c_i(bits_i[GRP_B+2]), .sc_o(grp[1]));
  ones_cnt_fa u_grp_c (.a_i(bits_i[GRP_C]), .b_i(bits_i[GRP_C+1]),
                       .c_i(bits_i[GRP_C+2]), .sc_o(grp[2]));

  // stage 2: weight-1 sums and weight-2 carries reduced separately
  ones_cnt_fa u_sums (.a_i(grp[0].s), .b_i(grp[1].s), .c_i(grp[2].s),
                      .sc_o(sum_tot));
  ones_cnt_fa u_cars (.a_i(grp[0].c), .b_i(grp[1].c), .c_i(grp[2].c),
                      .sc_o(car_tot));

  // stage 3: two weight-2 terms
  ones_cnt_ha u_w2 (.a_i(sum_tot.c), .b_i(car_tot.s), .sc_o(w2_mrg));
  // stage 4: two weight-4 terms
  ones_cnt_ha u_w4 (.a_i(w2_mrg.c), .b_i(car_tot.c), .sc_o(w4_mrg));

  assign count_o = {w4_mrg.c, w4_mrg.s, w2_mrg.s, sum_tot.s};
endmodule

// File: rtl/ones_cnt_tree_chk.sv
module ones_cnt_tree_chk
  import ones_cnt_pkg::*;
#(
  parameter int unsigned NUM_IN = 8
) (
  input logic [NUM_IN-1:0] bits_i,
  input logic [CNT_W-1:0]  count_o
);
  always_comb begin
    if (!$isunknown(bits_i)) begin
      // R1
      popcount_match_chk: assert (32'(count_o) == 32'($countones(bits_i)));
      // R4
      parity_lsb_chk: assert (count_o[0] == ^bits_i);
      // R5
      no_overflow_chk: assert (32'(count_o) <= NUM_IN);
      // R2 R3
      extreme_code_chk: assert (!(&bits_i) && (|bits_i) ||
                                ((&bits_i) && 32'(count_o) == NUM_IN) ||
                                (!(|bits_i) && count_o == '0));
    end
  end
endmodule

bind ones_cnt_tree ones_cnt_tree_chk #(.NUM_IN(NUM_IN)) u_chk (
  .bits_i (bits_i),
  .count_o(count_o)
);

// File: tb/ones_cnt_tree_tb.sv
module ones_cnt_tree_tb;
  logic       clk = 1'b0;
  logic [7:0] in8 = '0;
  logic [8:0] in9 = '0;
  logic [3:0] out8, out9;
  int         n_vec = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ones_cnt_tree #(.NUM_IN(8)) u_dut  (.bits_i(in8), .count_o(out8));
  ones_cnt_tree #(.NUM_IN(9)) u_dut9 (.bits_i(in9), .count_o(out9));

  function automatic int ref_cnt(input logic [8:0] v, input int n);
    int c = 0;
    for (int k = 0; k < n; k++) c += int'(v[k]);
    return c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive at posedge, sample at negedge
  task automatic apply(input logic [8:0] v8, input logic [8:0] v9);
    @(posedge clk);
    in8 = v8[7:0];
    in9 = v9;
    @(negedge clk);
  endtask

  initial begin
    // R3 reset-state equivalent: all zero
    apply(9'd0, 9'd0);
    chk("R3 zero 8", int'(out8), 0);
    chk("R3 zero 9", int'(out9), 0);
    // R2 all ones
    apply(9'h0FF, 9'h1FF);
    chk("R2 ones 8", int'(out8), 8);
    chk("R2 ones 9", int'(out9), 9);
    // R1 R4 R5 exhaustive sweep
    for (int v = 0; v < 512; v++) begin
      apply(9'(v), 9'(v));
      if (v < 256) begin
        chk("R1 sweep 8", int'(out8), ref_cnt(9'(v), 8));
        chk("R4 lsb 8", int'(out8[0]), ref_cnt(9'(v), 8) % 2);
        chk("R5 range 8", int'(out8 <= 4'd8), 1);
      end
      chk("R1 sweep 9", int'(out9), ref_cnt(9'(v), 9));
      chk("R4 lsb 9", int'(out9[0]), ref_cnt(9'(v), 9) % 2);
      chk("R5 range 9", int'(out9 <= 4'd9), 1);
    end
    // R6 position independence: walking ones and pairs
    for (int i = 0; i < 9; i++) begin
      apply(9'(1) << i, 9'(1) << i);
      if (i < 8) chk("R6 single 8", int'(out8), 1);
      chk("R6 single 9", int'(out9), 1);
      for (int j = i + 1; j < 9; j++) begin
        apply((9'(1) << i) | (9'(1) << j), (9'(1) << i) | (9'(1) << j));
        if (j < 8) chk("R6 pair 8", int'(out8), 2);
        chk("R6 pair 9", int'(out9), 2);
      end
    end
    // R7 both configurations present, all-ones codes differ by build
    apply(9'h0FF, 9'h1FF);
    chk("R7 cfg 8 code", int'(out8), 4'b1000);
    chk("R7 cfg 9 code", int'(out9), 4'b1001);
    // R8 no clock needed, no memory
    #1 in8 = 8'hA5; in9 = 9'h15A;
    #0.5;
    chk("R8 comb 8", int'(out8), 4);
    chk("R8 comb 9", int'(out9), 5);
    in8 = 8'h00; in9 = 9'h000;
    #0.5;
    in8 = 8'hA5; in9 = 9'h15A;
    #0.5;
    chk("R8 repeat 8", int'(out8), 4);
    chk("R8 repeat 9", int'(out9), 5);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule